// File: doc/BRIEF.md
# Adaptive Quantization Table Generator

This block builds a quantization table fitted to a single image. During a collection pass it takes in 8×8 transform coefficient blocks, one coefficient per beat, in raster order. Each block is tagged as luminance or chrominance. For each table it adds up the magnitude of every AC position across the frame. The DC position is left out.

An end-of-frame pulse starts the derivation. For each AC position the block scales a base table entry by the ratio of the largest per-position average to the average at that position, which is the same as dividing the entry by the normalized factor average/max. All blocks of one table share the same block count, so the ratio of averages equals the ratio of the magnitude sums. The block works with the sums and needs no block counter. One restoring division runs per position, and positions are visited one after another.

Software loads the base tables before a frame and reads the corrected tables once `done` is high.

Top module: `aqt_gen`

## Requirements
- R1: After reset `busy` and `done` are 0, `coef_ready` is 1 and `rd_data` reads 0 at every address.
- R2: A coefficient transfers on a clock edge where `coef_valid` and `coef_ready` are both 1. While `coef_valid` is 0 no beat is taken. Each block is 64 beats in raster order, where position p = 8·row + column. An internal position counter, reset by an accepted start-of-frame, tracks p. `coef_chroma` selects the table (0 luminance, 1 chrominance) and is held constant for a whole block.
- R3: The corrected DC entry (p = 0) equals the base DC entry, unchanged and unclamped. DC coefficients do not enter the statistics.
- R4: For AC position p of table t, let S be the sum of |coefficient| over all blocks of the frame, and M the largest S among the 63 AC positions of t. The corrected entry is floor(Q·M/S), where Q is the base entry.
- R5: An AC position with S = 0 keeps its base entry.
- R6: Every corrected AC entry is clamped to 1..255. A 0 becomes 1 and anything above 255 becomes 255.
- R7: Luminance and chrominance keep separate sums, maxima and corrected tables.
- R8: An `eof` pulse while idle raises `busy` on the next edge and clears `done`. When all 128 entries are written, `busy` falls and `done` rises on the same edge.
- R9: While `busy` is 1, `coef_ready` is 0. In that time coefficients, `sof`, `eof` and base-table writes have no effect.
- R10: An `sof` pulse while idle clears all sums, maxima and the position counter, and clears `done`.
- R11: Base writes (`bw_en`) and reads (`rd_addr`) use a 7-bit address. Bit 6 selects the table (0 luminance) and bits 5:0 give the raster position. `rd_data` follows `rd_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sof | input | 1 | Start-of-frame pulse, clears statistics |
| eof | input | 1 | End-of-frame pulse, starts table derivation |
| coef_valid | input | 1 | Coefficient beat valid |
| coef_ready | output | 1 | Coefficient beat accepted when high |
| coef_data | input | 16 | Signed coefficient |
| coef_chroma | input | 1 | Table tag of the current block |
| bw_en | input | 1 | Base table write enable |
| bw_addr | input | 7 | Base table write address |
| bw_data | input | 8 | Base table write data |
| rd_addr | input | 7 | Corrected table read address |
| rd_data | output | 8 | Corrected table entry |
| busy | output | 1 | Derivation in progress |
| done | output | 1 | Corrected tables complete |

## Verification
The hardest case to reach is the rule that inputs have no effect while busy. The derivation runs for several thousand cycles, and nothing inside it is visible until `done`. During that window the stimulus drives a coefficient beat, an `sof` pulse, an `eof` pulse and a base write all at once. It then starts a second derivation with no new frame. Both derivations must give exactly the tables of the original statistics, so any beat that slipped in, any cleared sum and any overwritten base entry shows up in the read-back. The clamp limits are reached on purpose: one position has a sum of one, and one position has both a zero base entry and zero statistics.

// File: rtl/aqt_pkg.sv
package aqt_pkg;
  localparam int unsigned POS_N  = 64;
  localparam int unsigned TBL_N  = 2;
  localparam int unsigned POS_W  = $clog2(POS_N);
  localparam int unsigned ADDR_W = POS_W + 1;
  localparam int unsigned ENT_N  = POS_N * TBL_N;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_EVAL = 2'd1,
    SQ_WAIT = 2'd2
  } seq_e;
endpackage

// File: rtl/aqt_stats.sv
module aqt_stats
  import aqt_pkg::*;
#(
  parameter int unsigned COEF_W = 16,
  parameter int unsigned ACC_W  = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 hold,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [COEF_W-1:0]    in_data,
  input  logic                 in_chroma,
  input  logic [ADDR_W-1:0]    rd_idx,
  output logic [ACC_W-1:0]     rd_acc,
  output logic [ACC_W-1:0]     rd_max
);
  logic [ACC_W-1:0]            acc_q [TBL_N][POS_N];
  logic [TBL_N-1:0][ACC_W-1:0] max_q;
  logic [POS_W-1:0]            pos_q;
  logic                        take;
  logic [COEF_W:0]             ext, mag;
  logic [ACC_W:0]              sum;
  logic [ACC_W-1:0]            sat;

  assign in_ready = !hold;
  assign take     = in_valid && !hold;

  always_comb begin
    ext = {in_data[COEF_W-1], in_data};
    mag = ext[COEF_W] ? (~ext + 1'b1) : ext;
    sum = {1'b0, acc_q[in_chroma][pos_q]} + {{(ACC_W-COEF_W){1'b0}}, mag};
    sat = sum[ACC_W] ? {ACC_W{1'b1}} : sum[ACC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      max_q <= '0;
      for (int t = 0; t < TBL_N; t++)
        for (int p = 0; p < POS_N; p++) acc_q[t][p] <= '0;
    end else if (clr) begin
      pos_q <= '0;
      max_q <= '0;
      for (int t = 0; t < TBL_N; t++)
        for (int p = 0; p < POS_N; p++) acc_q[t][p] <= '0;
    end else if (take) begin
      pos_q <= pos_q + 1'b1;
      if (pos_q != '0) begin
        acc_q[in_chroma][pos_q] <= sat;
        if (sat > max_q[in_chroma]) max_q[in_chroma] <= sat;
      end
    end
  end

  assign rd_acc = acc_q[rd_idx[ADDR_W-1]][rd_idx[POS_W-1:0]];
  assign rd_max = max_q[rd_idx[ADDR_W-1]];

  // R9
  stats_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !clr) |=> $stable(max_q) && $stable(pos_q));

  // R4
  max_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc <= rd_max);
endmodule

// File: rtl/aqt_div.sv
module aqt_div #(
  parameter int unsigned N_W = 40,
  parameter int unsigned D_W = 32,
  localparam int unsigned CNT_W = $clog2(N_W + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [N_W-1:0] num,
  input  logic [D_W-1:0] den,
  output logic [N_W-1:0] quo,
  output logic           done
);
  logic [N_W-1:0]   work_q;
  logic [D_W:0]     rem_q;
  logic [D_W-1:0]   den_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q, done_q;
  logic [D_W:0]     trial, diff;
  logic             ge;

  always_comb begin
    trial = {rem_q[D_W-1:0], work_q[N_W-1]};
    ge    = trial >= {1'b0, den_q};
    diff  = trial - {1'b0, den_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work_q <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start && !run_q) begin
        work_q <= num;
        rem_q  <= '0;
        den_q  <= den;
        cnt_q  <= CNT_W'(N_W);
        run_q  <= 1'b1;
      end else if (run_q) begin
        work_q <= {work_q[N_W-2:0], ge};
        rem_q  <= ge ? diff : trial;
        cnt_q  <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign quo  = work_q;
  assign done = done_q;

  // R4
  rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (rem_q < {1'b0, den_q}));

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
endmodule

// File: rtl/aqt_tables.sv
module aqt_tables
  import aqt_pkg::*;
#(
  parameter int unsigned Q_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bw_en,
  input  logic [ADDR_W-1:0] bw_addr,
  input  logic [Q_W-1:0]    bw_data,
  input  logic [ADDR_W-1:0] seq_idx,
  output logic [Q_W-1:0]    seq_base,
  input  logic              res_we,
  input  logic [Q_W-1:0]    res_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [Q_W-1:0]    rd_data
);
  logic [Q_W-1:0] base_q [ENT_N];
  logic [Q_W-1:0] res_q  [ENT_N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENT_N; i++) begin
        base_q[i] <= '0;
        res_q[i]  <= '0;
      end
    end else begin
      if (bw_en)  base_q[bw_addr] <= bw_data;
      if (res_we) res_q[seq_idx]  <= res_data;
    end
  end

  assign seq_base = base_q[seq_idx];
  assign rd_data  = res_q[rd_addr];

  // R6
  ac_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_we && seq_idx[POS_W-1:0] != '0) |-> (res_data != '0));

  // R3
  dc_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_we && seq_idx[POS_W-1:0] == '0) |-> (res_data == base_q[seq_idx]));
endmodule

// File: rtl/aqt_gen.sv
module aqt_gen
  import aqt_pkg::*;
#(
  parameter int unsigned COEF_W = 16,
  parameter int unsigned ACC_W  = 32,
  parameter int unsigned Q_W    = 8,
  localparam int unsigned N_W   = Q_W + ACC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sof,
  input  logic              eof,
  input  logic              coef_valid,
  output logic              coef_ready,
  input  logic [COEF_W-1:0] coef_data,
  input  logic              coef_chroma,
  input  logic              bw_en,
  input  logic [ADDR_W-1:0] bw_addr,
  input  logic [Q_W-1:0]    bw_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [Q_W-1:0]    rd_data,
  output logic              busy,
  output logic              done
);
  localparam logic [Q_W-1:0] Q_MAX = {Q_W{1'b1}};
  localparam logic [Q_W-1:0] Q_ONE = Q_W'(1);

  seq_e              st_q;
  logic [ADDR_W-1:0] idx_q;
  logic              busy_q, done_q;
  logic [ACC_W-1:0]  s_acc, s_max;
  logic [Q_W-1:0]    base_v, base_cl, quo_cl, res_v;
  logic [N_W-1:0]    prod, quo;
  logic              direct, div_start, div_done, res_we, last, clr;

  assign clr = sof && !busy_q;

  aqt_stats #(.COEF_W(COEF_W), .ACC_W(ACC_W)) u_stats (
    .clk(clk), .rst_n(rst_n), .clr(clr), .hold(busy_q),
    .in_valid(coef_valid), .in_ready(coef_ready),
    .in_data(coef_data), .in_chroma(coef_chroma),
    .rd_idx(idx_q), .rd_acc(s_acc), .rd_max(s_max)
  );

  aqt_tables #(.Q_W(Q_W)) u_tables (
    .clk(clk), .rst_n(rst_n),
    .bw_en(bw_en && !busy_q), .bw_addr(bw_addr), .bw_data(bw_data),
    .seq_idx(idx_q), .seq_base(base_v),
    .res_we(res_we), .res_data(res_v),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  aqt_div #(.N_W(N_W), .D_W(ACC_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start),
    .num(prod), .den(s_acc), .quo(quo), .done(div_done)
  );

  always_comb begin
    prod    = N_W'(base_v) * N_W'(s_max);
    direct  = (idx_q[POS_W-1:0] == '0) || (s_acc == '0);
    base_cl = (base_v == '0) ? Q_ONE : base_v;
    if (quo == '0)               quo_cl = Q_ONE;
    else if (quo > N_W'(Q_MAX))  quo_cl = Q_MAX;
    else                         quo_cl = quo[Q_W-1:0];
    if (idx_q[POS_W-1:0] == '0)  res_v = base_v;
    else if (st_q == SQ_EVAL)    res_v = base_cl;
    else                         res_v = quo_cl;
    div_start = (st_q == SQ_EVAL) && !direct;
    res_we    = ((st_q == SQ_EVAL) && direct) || ((st_q == SQ_WAIT) && div_done);
    last      = (idx_q == ADDR_W'(ENT_N - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      idx_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      case (st_q)
        SQ_IDLE: begin
          if (eof) begin
            st_q   <= SQ_EVAL;
            idx_q  <= '0;
            busy_q <= 1'b1;
            done_q <= 1'b0;
          end else if (sof) begin
            done_q <= 1'b0;
          end
        end
        SQ_EVAL, SQ_WAIT: begin
          if (res_we) begin
            if (last) begin
              st_q   <= SQ_IDLE;
              busy_q <= 1'b0;
              done_q <= 1'b1;
            end else begin
              st_q  <= SQ_EVAL;
              idx_q <= idx_q + 1'b1;
            end
          end else if (st_q == SQ_EVAL) begin
            st_q <= SQ_WAIT;
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign busy = busy_q;
  assign done = done_q;

  // R8
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !done_q);

  // R8
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(busy_q));

  // R10
  sof_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sof && !busy_q) |=> !done_q);

  // R9
  ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !coef_ready);
endmodule

// File: tb/tb_aqt_gen.sv
module tb_aqt_gen;
  logic       clk = 1'b0;
  logic       rst_n, sof, eof, coef_valid, coef_ready, coef_chroma;
  logic [15:0] coef_data;
  logic       bw_en;
  logic [6:0] bw_addr, rd_addr;
  logic [7:0] bw_data, rd_data;
  logic       busy, done;

  always #2.5 clk = ~clk;

  aqt_gen dut (
    .clk(clk), .rst_n(rst_n), .sof(sof), .eof(eof),
    .coef_valid(coef_valid), .coef_ready(coef_ready),
    .coef_data(coef_data), .coef_chroma(coef_chroma),
    .bw_en(bw_en), .bw_addr(bw_addr), .bw_data(bw_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .done(done)
  );

  int      checks = 0, errors = 0;
  int      q_exp[$];
  string   q_tag[$];
  longint  macc [2][64];
  int      basem[2][64];

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual 0 expected 1");
    summary();
    $finish;
  end

  function automatic int coefv(int t, int blk, int p, int fr);
    if (t == 0 && p == 63) return 0;
    if (t == 0 && p == 62) return (blk == 0) ? 1 : 0;
    if (t == 1 && p == 20) return 0;
    if (t == 0 && blk == 1 && p == 5 && fr == 0) return -32768;
    return (((blk * 37 + p * 11 + fr * 5 + t * 3) % 201) - 100) * (64 - p) / 4;
  endfunction

  function automatic int clampq(longint v);
    if (v <= 0) return 1;
    if (v > 255) return 255;
    return int'(v);
  endfunction

  task automatic write_base(int t, int p, int v);
    @(negedge clk);
    bw_en = 1'b1; bw_addr = 7'(t * 64 + p); bw_data = 8'(v);
    basem[t][p] = v;
    @(negedge clk);
    bw_en = 1'b0;
  endtask

  task automatic pulse_sof();
    @(negedge clk); sof = 1'b1;
    @(negedge clk); sof = 1'b0;
  endtask

  task automatic pulse_eof();
    @(negedge clk); eof = 1'b1;
    @(negedge clk); eof = 1'b0;
  endtask

  task automatic clear_model();
    for (int t = 0; t < 2; t++)
      for (int p = 0; p < 64; p++) macc[t][p] = 0;
  endtask

  // R2: one block, raster order, with idle gaps
  task automatic send_block(int t, int blk, int fr);
    for (int p = 0; p < 64; p++) begin
      int v;
      v = coefv(t, blk, p, fr);
      if (p % 9 == 4) begin
        @(negedge clk); coef_valid = 1'b0;
      end
      @(negedge clk);
      check(coef_ready == 1'b1, "R2 ready while idle", coef_ready, 1);
      coef_valid = 1'b1; coef_data = 16'(v); coef_chroma = t[0];
      if (p != 0) macc[t][p] += (v < 0) ? -v : v;
    end
    @(negedge clk); coef_valid = 1'b0;
  endtask

  // driver side of the scoreboard: expected corrected tables
  task automatic push_expected();
    for (int t = 0; t < 2; t++) begin
      longint m = 0;
      for (int p = 1; p < 64; p++) if (macc[t][p] > m) m = macc[t][p];
      for (int p = 0; p < 64; p++) begin
        longint raw;
        string tg;
        if (p == 0) begin
          q_exp.push_back(basem[t][p]); tg = "R3";
        end else if (macc[t][p] == 0) begin
          q_exp.push_back(clampq(basem[t][p])); tg = "R5";
        end else begin
          raw = longint'(basem[t][p]) * m / macc[t][p];
          q_exp.push_back(clampq(raw));
          tg = (raw > 255 || raw == 0) ? "R6" : "R4";
        end
        q_tag.push_back($sformatf("%s%s R11 pos %0d", (t == 1) ? "R7 " : "", tg, p));
      end
    end
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 30000) begin
      @(negedge clk); n++;
    end
    check(done == 1'b1 && busy == 1'b0, "R8 done after derivation", {busy, done}, 1);
  endtask

  // monitor side of the scoreboard
  task automatic drain(string note);
    for (int a = 0; a < 128; a++) begin
      int e;
      string tg;
      @(negedge clk);
      rd_addr = 7'(a);
      #1;
      e  = q_exp.pop_front();
      tg = q_tag.pop_front();
      check(rd_data == 8'(e), {note, " ", tg}, rd_data, e);
    end
  endtask

  initial begin
    rst_n = 1'b0; sof = 0; eof = 0; coef_valid = 0; coef_data = 0; coef_chroma = 0;
    bw_en = 0; bw_addr = 0; bw_data = 0; rd_addr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(busy == 0 && done == 0, "R1 busy/done after reset", {busy, done}, 0);
    check(coef_ready == 1, "R1 ready after reset", coef_ready, 1);
    foreach (q_exp[i]) ;
    rd_addr = 7'd0;   #1; check(rd_data == 0, "R1 rd_data addr 0", rd_data, 0);
    rd_addr = 7'd65;  #1; check(rd_data == 0, "R1 rd_data addr 65", rd_data, 0);
    rd_addr = 7'd127; #1; check(rd_data == 0, "R1 rd_data addr 127", rd_data, 0);

    // R11 base tables: luminance then chrominance
    for (int p = 0; p < 64; p++) write_base(0, p, (p == 0) ? 16 : 1 + (p * 3) % 200);
    for (int p = 0; p < 64; p++)
      write_base(1, p, (p == 10 || p == 20) ? 0 : 255 - p * 3);

    // frame 1
    pulse_sof();
    clear_model();
    send_block(0, 0, 0);
    send_block(1, 0, 0);
    send_block(0, 1, 0);
    send_block(0, 2, 0);
    send_block(1, 1, 0);
    send_block(0, 3, 0);
    pulse_eof();
    // R8, R9
    check(busy == 1, "R8 busy after eof", busy, 1);
    check(coef_ready == 0, "R9 ready low while busy", coef_ready, 0);
    check(done == 0, "R8 done low while busy", done, 0);
    // R9: all of these are to be ignored
    @(negedge clk);
    coef_valid = 1; coef_data = 16'd12345; coef_chroma = 0;
    sof = 1; eof = 1; bw_en = 1; bw_addr = 7'd1; bw_data = 8'd200;
    @(negedge clk);
    coef_valid = 0; sof = 0; eof = 0; bw_en = 0;
    wait_done();
    push_expected();
    drain("frame1");

    // R9: recompute without a new frame, results must be unchanged
    pulse_eof();
    check(done == 0, "R8 done cleared by eof", done, 0);
    wait_done();
    push_expected();
    drain("R9 rerun");

    // frame 2, R10 clears statistics and done
    pulse_sof();
    check(done == 0, "R10 done cleared by sof", done, 0);
    clear_model();
    send_block(1, 4, 1);
    send_block(0, 5, 1);
    send_block(1, 6, 1);
    send_block(0, 7, 1);
    send_block(1, 8, 1);
    pulse_eof();
    wait_done();
    push_expected();
    drain("R10 frame2");

    summary();
    $finish;
  end
endmodule